// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data-memory addresses for indirect accesses. It holds four index pointers, four modify values, four length values and four buffer bases. An access names one pointer and one modify value. The block puts the pointer's current value on the address output. In the same clock edge it advances that pointer by the chosen modify value, which is post-modify addressing.

A non-zero length turns the selected pointer into a circular buffer. The buffer runs from its base up to base plus length minus one. A post-modified value that leaves this window is folded back by one length. A length of zero gives plain linear stepping in 14-bit two's-complement arithmetic. Writing a pointer also records its value as that buffer's base. An optional output stage reverses the bit order of the emitted address, for example to walk FFT data in bit-reversed order. A build parameter removes this stage for an instance that does not need it.

Software-side access uses a register write port and a combinational read port. Both select a register by a kind code and an index.

Top module: `circ_dag`

## Requirements
- R1: While reset is low, and after it is released, every register reads zero, `addr_valid` is 0 and `addr_out` is 0.
- R2: `wr_kind` and `rd_kind` use these codes: 0 selects an index pointer, 1 a modify value, 2 a length value and 3 a buffer base. A write stores `wr_data` into the register selected by kind and `wr_idx`. `rd_data` shows the register selected by `rd_kind`/`rd_idx` in the same cycle. A write with kind 3 changes no register.
- R3: An access is `acc_en` high while `wr_en` is low. In the cycle after an access, `addr_valid` is 1 and `addr_out` holds the pointer value from before the access. In every other cycle `addr_valid` is 0 and `addr_out` keeps its previous value.
- R4: After an access, the selected pointer equals its old value plus the modify register selected by `acc_mod`. The modify value is read as 14-bit two's complement.
- R5: When the pointer's length is zero, the post-modify wraps modulo 2^14 with no buffer window.
- R6: When length L is non-zero and base is B, a post-modified value at or above B+L is reduced by L.
- R7: When length L is non-zero and base is B, a post-modified value below B is increased by L.
- R8: A write to pointer n also sets base n to the written value.
- R9: When `BITREV` is 1 and `bitrev_en` is high during an access, `addr_out` is the pointer with bit 0 swapped with bit 13, bit 1 with bit 12, and so on. The stored pointer keeps normal bit order and advances normally.
- R10: When `wr_en` and `acc_en` are both high, the write takes effect and the access is dropped. `addr_valid` stays 0 and no pointer is post-modified.
- R11: An access changes only the selected pointer. The other pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind for the write (0 pointer, 1 modify, 2 length, 3 base) |
| wr_idx | input | 2 | Register index for the write |
| wr_data | input | 14 | Write data |
| rd_kind | input | 2 | Register kind for the read |
| rd_idx | input | 2 | Register index for the read |
| rd_data | output | 14 | Combinational read data |
| acc_en | input | 1 | Indirect access strobe |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_mod | input | 2 | Modify register used by the access |
| bitrev_en | input | 1 | Reverse the bits of the emitted address |
| addr_out | output | 14 | Registered address |
| addr_valid | output | 1 | High for one cycle after each access |

## Verification
The bench drives a circular buffer up past its top so that it must fold down. It also drives a buffer down past its base so that it must fold up. A design that compares against the wrong bound, or adds where it should subtract, leaves the window at that point. The bench steps a linear pointer across the 14-bit rollover and uses a negative modify value, which exposes a missing sign extension or a wrong width. A write and an access in the same cycle check that the access is fully dropped, both the valid pulse and the pointer update. Accesses with bit reversal on check that the reversal reaches only the output, so a design that stores the reversed pointer falls out of step at once.

// File: rtl/circ_dag_pkg.sv
package circ_dag_pkg;

    typedef enum logic [1:0] {
        KIND_PTR  = 2'd0,
        KIND_MOD  = 2'd1,
        KIND_LEN  = 2'd2,
        KIND_BASE = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
    import circ_dag_pkg::*;
#(
    parameter int AW   = 14,
    parameter int NBUF = 4,
    parameter int IDXW = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  reg_kind_e                 wr_kind,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [AW-1:0]             wr_data,
    input  logic                      upd_en,
    input  logic [IDXW-1:0]           upd_idx,
    input  logic [AW-1:0]             upd_val,
    input  reg_kind_e                 rd_kind,
    input  logic [IDXW-1:0]           rd_idx,
    output logic [AW-1:0]             rd_data,
    output logic [NBUF-1:0][AW-1:0]   ptr_q,
    output logic [NBUF-1:0][AW-1:0]   mod_q,
    output logic [NBUF-1:0][AW-1:0]   len_q,
    output logic [NBUF-1:0][AW-1:0]   base_q
);

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic hit_w;
        logic hit_u;

        assign hit_w = wr_en && (wr_idx == IDXW'(g));
        assign hit_u = upd_en && (upd_idx == IDXW'(g));

        // pointer: a write wins over a post-modify update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (hit_w && wr_kind == KIND_PTR) begin
                ptr_q[g] <= wr_data;
            end else if (hit_u) begin
                ptr_q[g] <= upd_val;
            end
        end

        // base follows every pointer write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
            end else if (hit_w && wr_kind == KIND_PTR) begin
                base_q[g] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mod_q[g] <= '0;
            end else if (hit_w && wr_kind == KIND_MOD) begin
                mod_q[g] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q[g] <= '0;
            end else if (hit_w && wr_kind == KIND_LEN) begin
                len_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        unique case (rd_kind)
            KIND_PTR:  rd_data = ptr_q[rd_idx];
            KIND_MOD:  rd_data = mod_q[rd_idx];
            KIND_LEN:  rd_data = len_q[rd_idx];
            KIND_BASE: rd_data = base_q[rd_idx];
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dag_modulo.sv
module dag_modulo #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] modv,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);

    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum_s;
    logic signed [EW-1:0] lo_s;
    logic signed [EW-1:0] len_s;
    logic signed [EW-1:0] hi_s;
    logic signed [EW-1:0] down_s;
    logic signed [EW-1:0] up_s;
    logic                 circ;

    always_comb begin
        sum_s  = $signed({2'b00, ptr}) + $signed({{2{modv[AW-1]}}, modv});
        lo_s   = $signed({2'b00, base});
        len_s  = $signed({2'b00, len});
        hi_s   = lo_s + len_s;
        down_s = sum_s - len_s;
        up_s   = sum_s + len_s;
        circ   = (len != '0);

        if (!circ) begin
            nxt = sum_s[AW-1:0];
        end else if (sum_s >= hi_s) begin
            nxt = down_s[AW-1:0];
        end else if (sum_s < lo_s) begin
            nxt = up_s[AW-1:0];
        end else begin
            nxt = sum_s[AW-1:0];
        end
    end

endmodule

// File: rtl/dag_outstage.sv
module dag_outstage #(
    parameter int AW     = 14,
    parameter bit BITREV = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [AW-1:0] ptr_in,
    input  logic          bitrev_en,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid
);

    logic [AW-1:0] addr_sel;

    if (BITREV) begin : g_rev
        logic [AW-1:0] rev;
        always_comb begin
            for (int b = 0; b < AW; b++) begin
                rev[b] = ptr_in[AW-1-b];
            end
        end
        assign addr_sel = bitrev_en ? rev : ptr_in;
    end else begin : g_norev
        assign addr_sel = ptr_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            addr_out   <= '0;
        end else begin
            addr_valid <= fire;
            if (fire) begin
                addr_out <= addr_sel;
            end
        end
    end

endmodule

// File: rtl/circ_dag.sv
module circ_dag
    import circ_dag_pkg::*;
#(
    parameter int AW     = 14,
    parameter int NBUF   = 4,
    parameter int IDXW   = $clog2(NBUF),
    parameter bit BITREV = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic [1:0]      rd_kind,
    input  logic [IDXW-1:0] rd_idx,
    output logic [AW-1:0]   rd_data,
    input  logic            acc_en,
    input  logic [IDXW-1:0] acc_ptr,
    input  logic [IDXW-1:0] acc_mod,
    input  logic            bitrev_en,
    output logic [AW-1:0]   addr_out,
    output logic            addr_valid
);

    reg_kind_e                 wr_kind_e;
    reg_kind_e                 rd_kind_e;
    logic                      fire;
    logic [AW-1:0]             nxt_ptr;
    logic [NBUF-1:0][AW-1:0]   ptr_q;
    logic [NBUF-1:0][AW-1:0]   mod_q;
    logic [NBUF-1:0][AW-1:0]   len_q;
    logic [NBUF-1:0][AW-1:0]   base_q;

    assign wr_kind_e = reg_kind_e'(wr_kind);
    assign rd_kind_e = reg_kind_e'(rd_kind);
    // a register write in the same cycle drops the access
    assign fire      = acc_en && !wr_en;

    dag_regfile #(.AW(AW), .NBUF(NBUF), .IDXW(IDXW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind_e),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (fire),
        .upd_idx (acc_ptr),
        .upd_val (nxt_ptr),
        .rd_kind (rd_kind_e),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .ptr_q   (ptr_q),
        .mod_q   (mod_q),
        .len_q   (len_q),
        .base_q  (base_q)
    );

    dag_modulo #(.AW(AW)) u_wrap (
        .ptr  (ptr_q[acc_ptr]),
        .modv (mod_q[acc_mod]),
        .len  (len_q[acc_ptr]),
        .base (base_q[acc_ptr]),
        .nxt  (nxt_ptr)
    );

    dag_outstage #(.AW(AW), .BITREV(BITREV)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .ptr_in     (ptr_q[acc_ptr]),
        .bitrev_en  (bitrev_en),
        .addr_out   (addr_out),
        .addr_valid (addr_valid)
    );

endmodule

// File: rtl/circ_dag_chk.sv
module circ_dag_chk #(
    parameter int AW   = 14,
    parameter int NBUF = 4,
    parameter int IDXW = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [1:0]              wr_kind,
    input logic [IDXW-1:0]         wr_idx,
    input logic [AW-1:0]           wr_data,
    input logic                    acc_en,
    input logic [IDXW-1:0]         acc_ptr,
    input logic [IDXW-1:0]         acc_mod,
    input logic [AW-1:0]           addr_out,
    input logic                    addr_valid,
    input logic [NBUF-1:0][AW-1:0] ptr_q,
    input logic [NBUF-1:0][AW-1:0] mod_q,
    input logic [NBUF-1:0][AW-1:0] len_q,
    input logic [NBUF-1:0][AW-1:0] base_q
);

    logic          acc_ok;
    logic [AW-1:0] mod_sel;
    logic [AW:0]   mag;

    assign acc_ok  = acc_en && !wr_en;
    assign mod_sel = mod_q[acc_mod];
    assign mag     = mod_sel[AW-1] ? ({1'b0, ~mod_sel} + 1'b1) : {1'b0, mod_sel};

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !addr_valid && addr_out == '0); // R1

    AST_VALID_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |=> addr_valid); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |=> !addr_valid && $stable(addr_out)); // R3

    AST_WRITE_DROPS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_en |=> !addr_valid); // R10

    AST_BASE_ON_PTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_kind == 2'd0 |=> base_q[$past(wr_idx)] == $past(wr_data)); // R8

    for (genvar g = 0; g < NBUF; g++) begin : g_chk
        logic [AW:0] off;
        logic        in_win;
        logic        fits;

        assign off    = {1'b0, ptr_q[g]} - {1'b0, base_q[g]};
        assign in_win = (ptr_q[g] >= base_q[g]) && (off < {1'b0, len_q[g]});
        assign fits   = ({1'b0, base_q[g]} + {1'b0, len_q[g]}) <= (AW+1)'(1 << AW);

        AST_OTHER_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            acc_ok && acc_ptr != IDXW'(g) |=> $stable(ptr_q[g])); // R11

        AST_WRAP_STAYS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            acc_ok && acc_ptr == IDXW'(g) && len_q[g] != '0 && in_win && fits
                && mag < {1'b0, len_q[g]} |=> in_win); // R6 R7
    end

endmodule

bind circ_dag circ_dag_chk #(.AW(AW), .NBUF(NBUF), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_kind    (wr_kind),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .acc_en     (acc_en),
    .acc_ptr    (acc_ptr),
    .acc_mod    (acc_mod),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .ptr_q      (ptr_q),
    .mod_q      (mod_q),
    .len_q      (len_q),
    .base_q     (base_q)
);

// File: tb/circ_dag_test.sv
`timescale 1ns/10ps
module circ_dag_test;

    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [1:0]    wr_kind;
    logic [1:0]    wr_idx;
    logic [AW-1:0] wr_data;
    logic [1:0]    rd_kind;
    logic [1:0]    rd_idx;
    logic [AW-1:0] rd_data;
    logic          acc_en;
    logic [1:0]    acc_ptr;
    logic [1:0]    acc_mod;
    logic          bitrev_en;
    logic [AW-1:0] addr_out;
    logic          addr_valid;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [AW-1:0] mi [4];
    logic [AW-1:0] mm [4];
    logic [AW-1:0] ml [4];
    logic [AW-1:0] mb [4];
    logic [AW-1:0] exp_addr;
    logic          exp_valid;

    always #2.5 clk = ~clk;

    circ_dag uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_kind    (rd_kind),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .acc_en     (acc_en),
        .acc_ptr    (acc_ptr),
        .acc_mod    (acc_mod),
        .bitrev_en  (bitrev_en),
        .addr_out   (addr_out),
        .addr_valid (addr_valid)
    );

    function automatic logic [AW-1:0] f_rev(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int b = 0; b < AW; b++) r[b] = v[AW-1-b];
        return r;
    endfunction

    function automatic logic [AW-1:0] f_next(input logic [AW-1:0] i, input logic [AW-1:0] m,
                                             input logic [AW-1:0] l, input logic [AW-1:0] b);
        int s;
        int md;
        md = int'(m);
        if (m[AW-1]) md = md - (1 << AW);
        s = int'(i) + md;
        if (l != '0) begin
            if (s >= int'(b) + int'(l)) s = s - int'(l);
            else if (s < int'(b)) s = s + int'(l);
        end
        return AW'(s & ((1 << AW) - 1));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // one clocked cycle, entered and left at a falling edge
    task automatic cyc(input bit w, input logic [1:0] k, input logic [1:0] wi,
                       input logic [AW-1:0] wd, input bit a, input logic [1:0] ap,
                       input logic [1:0] am, input bit br, input string tag);
        logic [AW-1:0] cur;
        wr_en = w; wr_kind = k; wr_idx = wi; wr_data = wd;
        acc_en = a; acc_ptr = ap; acc_mod = am; bitrev_en = br;
        if (w) begin
            case (k)
                2'd0: begin mi[wi] = wd; mb[wi] = wd; end
                2'd1: mm[wi] = wd;
                2'd2: ml[wi] = wd;
                default: ;
            endcase
            exp_valid = 1'b0;
        end else if (a) begin
            cur       = mi[ap];
            exp_addr  = br ? f_rev(cur) : cur;
            exp_valid = 1'b1;
            mi[ap]    = f_next(cur, mm[am], ml[ap], mb[ap]);
        end else begin
            exp_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(addr_valid == exp_valid, {tag, " valid"}, int'(addr_valid), int'(exp_valid));
        chk(addr_out == exp_addr, {tag, " addr"}, int'(addr_out), int'(exp_addr));
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; acc_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] k, input logic [1:0] i, input logic [AW-1:0] e,
                      input string tag);
        rd_kind = k; rd_idx = i;
        #0.1;
        chk(rd_data == e, tag, int'(rd_data), int'(e));
    endtask

    task automatic readall(input string tag);
        idle_inputs();
        for (int i = 0; i < 4; i++) begin
            rd(2'd0, 2'(i), mi[i], {tag, " R2 ptr"});
            rd(2'd1, 2'(i), mm[i], {tag, " R2 mod"});
            rd(2'd2, 2'(i), ml[i], {tag, " R2 len"});
            rd(2'd3, 2'(i), mb[i], {tag, " R8 base"});
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            mi[i] = '0; mm[i] = '0; ml[i] = '0; mb[i] = '0;
        end
        exp_addr = '0; exp_valid = 1'b0;
        rst_n = 1'b0; wr_en = 1'b0; wr_kind = 2'd0; wr_idx = 2'd0; wr_data = '0;
        rd_kind = 2'd0; rd_idx = 2'd0; acc_en = 1'b0; acc_ptr = 2'd0; acc_mod = 2'd0;
        bitrev_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(addr_valid == 1'b0, "R1 valid in reset", int'(addr_valid), 0);
        chk(addr_out == '0, "R1 addr in reset", int'(addr_out), 0);
        readall("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        readall("R1 after release");

        // R4 R5: linear post-modify, positive and negative
        cyc(1, 2'd0, 2'd0, 14'd100, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(1, 2'd1, 2'd0, 14'd3, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd0, 2'd0, 0, "R3 R4 linear");
        rd(2'd0, 2'd0, 14'd103, "R4 ptr after +3");
        cyc(1, 2'd1, 2'd1, 14'h3FFB, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd0, 2'd1, 0, "R4 negative");
        rd(2'd0, 2'd0, 14'd98, "R4 ptr after -5");

        // R5: rollover at 2^14
        cyc(1, 2'd0, 2'd1, 14'd16382, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(1, 2'd1, 2'd2, 14'd4, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd1, 2'd2, 0, "R5 rollover");
        rd(2'd0, 2'd1, 14'd2, "R5 ptr rolled");

        // R6: fold down at the top
        cyc(1, 2'd0, 2'd2, 14'd200, 0, 2'd0, 2'd0, 0, "R8 wr");
        rd(2'd3, 2'd2, 14'd200, "R8 base set");
        cyc(1, 2'd2, 2'd2, 14'd10, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(1, 2'd1, 2'd3, 14'd4, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd2, 2'd3, 0, "R6 step");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd2, 2'd3, 0, "R6 step");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd2, 2'd3, 0, "R6 step");
        rd(2'd0, 2'd2, 14'd202, "R6 folded down");

        // R7: fold up at the base
        cyc(1, 2'd0, 2'd3, 14'd50, 0, 2'd0, 2'd0, 0, "R8 wr");
        cyc(1, 2'd2, 2'd3, 14'd8, 0, 2'd0, 2'd0, 0, "R2 wr");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd3, 2'd1, 0, "R7 step");
        rd(2'd0, 2'd3, 14'd53, "R7 folded up");
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd3, 2'd1, 0, "R7 step");
        rd(2'd0, 2'd3, 14'd56, "R7 folded up again");
        rd(2'd0, 2'd2, 14'd202, "R11 other ptr kept");

        // R9: reversed output, normal stored pointer
        cyc(0, 2'd0, 2'd0, '0, 1, 2'd0, 2'd0, 1, "R9 bitrev");
        rd(2'd0, 2'd0, 14'd101, "R9 stored order");

        // R10: write wins, access dropped, addr_out held
        cyc(1, 2'd1, 2'd0, 14'd2, 1, 2'd0, 2'd0, 0, "R10 collide");
        rd(2'd0, 2'd0, 14'd101, "R10 ptr unchanged");
        rd(2'd1, 2'd0, 14'd2, "R10 write taken");

        // R2: base kind is not writable
        cyc(1, 2'd3, 2'd2, 14'd777, 0, 2'd0, 2'd0, 0, "R2 base write");
        rd(2'd3, 2'd2, 14'd200, "R2 base unchanged");
        readall("directed");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int r;
            int k;
            logic [AW-1:0] d;
            r = int'($urandom % 100);
            k = int'($urandom % 4);
            case (k)
                0: d = AW'($urandom % 16000);
                1: d = AW'(int'($urandom % 15) - 7);
                2: d = ($urandom % 3 == 0) ? '0 : AW'(8 + $urandom % 33);
                default: d = AW'($urandom);
            endcase
            if (r < 15)
                cyc(1, 2'(k), 2'($urandom), d, 0, 2'($urandom), 2'($urandom), 0, "R2 rnd wr");
            else if (r < 20)
                cyc(1, 2'(k), 2'($urandom), d, 1, 2'($urandom), 2'($urandom), 0, "R10 rnd");
            else if (r < 90)
                cyc(0, 2'd0, 2'd0, '0, 1, 2'($urandom), 2'($urandom), 1'($urandom),
                    "R3 R4 R6 R7 R9 rnd");
            else
                cyc(0, 2'd0, 2'd0, '0, 0, 2'd0, 2'd0, 0, "R3 rnd idle");
            if (n % 500 == 499) readall("R11 rnd");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule